// File: doc/BRIEF.md
# Speed-Mode PHY Configuration Controller

This block turns a requested bus timing mode for an SD/eMMC host into the control bits of the host PHY. It sets the per-lane DDR enables for data, the DDR enable for the command line, the data asynchronous-sampling enable, the SDIO-mode bit and the slow-mode (PHY bypass) bit. Each request carries a mode code, a flag that the card clock runs above 52 MHz, a flag that the card is an SDIO card, and a board strap asking for slow mode.

The function-control bits (data DDR, command DDR, async) may only change while the card clock is stopped. The controller therefore asks for the clock to be gated, waits for the acknowledge, writes the bits, releases the gate and waits for the acknowledge to drop, and then starts the PHY init sequencer and waits for it to finish. Legacy mode and any request that picks slow mode leave the function-control bits alone and go directly to init. A request that repeats the last applied mode, clock class and card type finishes at once.

The sequencer has six named states. IDLE accepts a request. It moves to GATE for a normal change, to INIT for a legacy or slow request, and it stays in IDLE for a repeat. GATE holds the gate request until the acknowledge arrives, then goes to WRITE. WRITE loads the function-control bits and goes to UNGATE. UNGATE releases the gate and waits for the acknowledge to clear, then goes to INIT. INIT pulses the init start for one cycle and goes to WAIT_DONE. WAIT_DONE waits for init complete and returns to IDLE.

Top module: `phy_mode_cfg_ctrl`

## Requirements
- R1: After reset: all data DDR enables 0, command DDR 0, async 1, SDIO mode 0, slow mode 0, ready 1, gate request 0, init start 0, done 0.
- R2: Mode code 10 (HS400), when the function-control bits are written: every data-lane DDR enable 1, command DDR 1, async 0.
- R3: Mode codes 7 (DDR50) and 8 (DDR52), when written: every data-lane DDR enable 1, command DDR 1, async 1.
- R4: Any other code written (1..6, 9, 11..15): every data-lane DDR enable 0, command DDR 0, async 1.
- R5: A request that flags the clock above 52 MHz always leaves slow mode at 0.
- R6: Below 52 MHz, slow mode works as follows. Code 0 (legacy) sets it to the strap. Codes 1 (MMC high speed), 2 (SD high speed), 3 (SDR12) and 4 (SDR25) set it to SDIO OR strap. Every other code sets it to 0.
- R7: For a non-legacy request, the SDIO-mode bit takes the request's SDIO flag. A legacy request leaves it unchanged.
- R8: The function-control bits change only while the gate request and its acknowledge are both high. Init start is raised only after the gate is released and the acknowledge is low.
- R9: A legacy request, or one that selects slow mode, never raises the gate request and leaves the function-control bits unchanged.
- R10: A request that is applied produces exactly one single-cycle init start pulse. The done pulse comes one cycle after init complete is seen, and ready returns then.
- R11: A request whose mode, clock flag and SDIO flag equal the last applied ones gives done in the next cycle, with no gate request and no init start.
- R12: A request presented while ready is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only while ready |
| req_mode | input | MODE_W | Timing mode code |
| req_fast | input | 1 | Card clock above 52 MHz |
| req_sdio | input | 1 | Card is SDIO |
| slow_strap | input | 1 | Board asks for slow mode |
| ready | output | 1 | Sequencer idle |
| req_done | output | 1 | One-cycle completion pulse |
| clk_gate_req | output | 1 | Request to stop the card clock |
| clk_gate_ack | input | 1 | Card clock is stopped |
| init_start | output | 1 | One-cycle PHY init start |
| init_done | input | 1 | PHY init complete |
| dq_ddr_en | output | DQ_LANES | Per-lane data DDR enable |
| cmd_ddr_en | output | 1 | Command line DDR enable |
| dq_async_en | output | 1 | Data async sampling enable |
| sdio_mode | output | 1 | SDIO mode bit |
| slow_mode | output | 1 | PHY slow/bypass mode bit |

## Verification
Some rules are checked by assertions on every cycle. These are: function-control bits never move outside a gated-and-acknowledged window, init start is a single pulse issued with the clock ungated, idle never coincides with a gate request, slow mode is clear after a fast request, and legacy leaves the SDIO bit alone. Other behaviour needs the bench's request scenarios. These are the exact DDR/async encoding per mode group, the slow-mode truth table over mode, SDIO and strap, the bypass of the write for legacy and slow requests, the immediate completion of repeated requests, and the dropping of requests made while busy.

// File: rtl/phycfg_pkg.sv
package phycfg_pkg;

    // Mode codes; the decoder's grouping depends on these values
    localparam int TM_LEGACY  = 0;
    localparam int TM_MMC_HS  = 1;
    localparam int TM_SD_HS   = 2;
    localparam int TM_SDR12   = 3;
    localparam int TM_SDR25   = 4;
    localparam int TM_SDR50   = 5;
    localparam int TM_SDR104  = 6;
    localparam int TM_DDR50   = 7;
    localparam int TM_DDR52   = 8;
    localparam int TM_HS200   = 9;
    localparam int TM_HS400   = 10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATE,
        ST_WRITE,
        ST_UNGATE,
        ST_INIT,
        ST_WAIT_DONE
    } seq_state_t;

endpackage

// File: rtl/phycfg_mode_decode.sv
module phycfg_mode_decode
    import phycfg_pkg::*;
#(
    parameter int MODE_W   = 4,
    parameter int DQ_LANES = 8
) (
    input  logic [MODE_W-1:0]   mode,
    input  logic                fast,
    input  logic                sdio,
    input  logic                strap,
    output logic                is_legacy,
    output logic                slow_sel,
    output logic                skip_write,
    output logic [DQ_LANES-1:0] dq_ddr_val,
    output logic                cmd_ddr_val,
    output logic                async_val
);

    logic low_speed_grp;
    logic ddr_grp;
    logic hs400;

    always_comb begin
        is_legacy     = (mode == MODE_W'(TM_LEGACY));
        low_speed_grp = (mode == MODE_W'(TM_MMC_HS)) || (mode == MODE_W'(TM_SD_HS)) ||
                        (mode == MODE_W'(TM_SDR12))  || (mode == MODE_W'(TM_SDR25));
        ddr_grp       = (mode == MODE_W'(TM_DDR50)) || (mode == MODE_W'(TM_DDR52));
        hs400         = (mode == MODE_W'(TM_HS400));

        if (fast)
            slow_sel = 1'b0;
        else if (is_legacy)
            slow_sel = strap;
        else if (low_speed_grp)
            slow_sel = sdio | strap;
        else
            slow_sel = 1'b0;

        skip_write = is_legacy | slow_sel;

        if (hs400) begin
            dq_ddr_val  = '1;
            cmd_ddr_val = 1'b1;
            async_val   = 1'b0;
        end else if (ddr_grp) begin
            dq_ddr_val  = '1;
            cmd_ddr_val = 1'b1;
            async_val   = 1'b1;
        end else begin
            dq_ddr_val  = '0;
            cmd_ddr_val = 1'b0;
            async_val   = 1'b1;
        end
    end

endmodule

// File: rtl/phycfg_cfg_regs.sv
module phycfg_cfg_regs #(
    parameter int MODE_W   = 4,
    parameter int DQ_LANES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                apply,
    input  logic                wr_en,
    input  logic [MODE_W-1:0]   req_mode,
    input  logic                req_fast,
    input  logic                req_sdio,
    input  logic                dec_legacy,
    input  logic                dec_slow,
    input  logic [DQ_LANES-1:0] dec_dq_ddr,
    input  logic                dec_cmd_ddr,
    input  logic                dec_async,
    output logic                hit,
    output logic [DQ_LANES-1:0] dq_ddr_en,
    output logic                cmd_ddr_en,
    output logic                dq_async_en,
    output logic                sdio_mode,
    output logic                slow_mode
);

    logic [MODE_W-1:0] last_mode;
    logic              last_fast;
    logic              last_sdio;
    logic              last_valid;
    logic              pend_cmd;
    logic              pend_async;

    assign hit = last_valid && (req_mode == last_mode) &&
                 (req_fast == last_fast) && (req_sdio == last_sdio);

    // Per-lane staged and applied DDR enables
    for (genvar g = 0; g < DQ_LANES; g++) begin : g_lane
        logic pend_q;
        logic live_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q <= 1'b0;
                live_q <= 1'b0;
            end else begin
                if (apply)
                    pend_q <= dec_dq_ddr[g];
                if (wr_en)
                    live_q <= pend_q;
            end
        end
        assign dq_ddr_en[g] = live_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_mode   <= '0;
            last_fast   <= 1'b0;
            last_sdio   <= 1'b0;
            last_valid  <= 1'b0;
            pend_cmd    <= 1'b0;
            pend_async  <= 1'b1;
            cmd_ddr_en  <= 1'b0;
            dq_async_en <= 1'b1;
            sdio_mode   <= 1'b0;
            slow_mode   <= 1'b0;
        end else begin
            if (apply) begin
                last_mode  <= req_mode;
                last_fast  <= req_fast;
                last_sdio  <= req_sdio;
                last_valid <= 1'b1;
                pend_cmd   <= dec_cmd_ddr;
                pend_async <= dec_async;
                slow_mode  <= dec_slow;
                if (!dec_legacy)
                    sdio_mode <= req_sdio;
            end
            if (wr_en) begin
                cmd_ddr_en  <= pend_cmd;
                dq_async_en <= pend_async;
            end
        end
    end

endmodule

// File: rtl/phycfg_seq_fsm.sv
module phycfg_seq_fsm
    import phycfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic hit,
    input  logic skip_write,
    input  logic clk_gate_ack,
    input  logic init_done,
    output logic ready,
    output logic apply,
    output logic wr_en,
    output logic clk_gate_req,
    output logic init_start,
    output logic req_done
);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_IDLE && req_valid && hit) ||
                       (state_q == ST_WAIT_DONE && init_done);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && !hit)
                    state_d = skip_write ? ST_INIT : ST_GATE;
            end
            ST_GATE:      if (clk_gate_ack) state_d = ST_WRITE;
            ST_WRITE:     state_d = ST_UNGATE;
            ST_UNGATE:    if (!clk_gate_ack) state_d = ST_INIT;
            ST_INIT:      state_d = ST_WAIT_DONE;
            ST_WAIT_DONE: if (init_done) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready        = (state_q == ST_IDLE);
        apply        = ready && req_valid && !hit;
        wr_en        = (state_q == ST_WRITE);
        clk_gate_req = (state_q == ST_GATE) || (state_q == ST_WRITE);
        init_start   = (state_q == ST_INIT);
        req_done     = done_q;
    end

endmodule

// File: rtl/phy_mode_cfg_ctrl.sv
module phy_mode_cfg_ctrl #(
    parameter int MODE_W   = 4,
    parameter int DQ_LANES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [MODE_W-1:0]   req_mode,
    input  logic                req_fast,
    input  logic                req_sdio,
    input  logic                slow_strap,
    output logic                ready,
    output logic                req_done,
    output logic                clk_gate_req,
    input  logic                clk_gate_ack,
    output logic                init_start,
    input  logic                init_done,
    output logic [DQ_LANES-1:0] dq_ddr_en,
    output logic                cmd_ddr_en,
    output logic                dq_async_en,
    output logic                sdio_mode,
    output logic                slow_mode
);

    logic                dec_legacy;
    logic                dec_slow;
    logic                dec_skip;
    logic [DQ_LANES-1:0] dec_dq;
    logic                dec_cmd;
    logic                dec_async;
    logic                hit;
    logic                apply;
    logic                wr_en;

    phycfg_mode_decode #(.MODE_W(MODE_W), .DQ_LANES(DQ_LANES)) u_decode (
        .mode        (req_mode),
        .fast        (req_fast),
        .sdio        (req_sdio),
        .strap       (slow_strap),
        .is_legacy   (dec_legacy),
        .slow_sel    (dec_slow),
        .skip_write  (dec_skip),
        .dq_ddr_val  (dec_dq),
        .cmd_ddr_val (dec_cmd),
        .async_val   (dec_async)
    );

    phycfg_cfg_regs #(.MODE_W(MODE_W), .DQ_LANES(DQ_LANES)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .apply       (apply),
        .wr_en       (wr_en),
        .req_mode    (req_mode),
        .req_fast    (req_fast),
        .req_sdio    (req_sdio),
        .dec_legacy  (dec_legacy),
        .dec_slow    (dec_slow),
        .dec_dq_ddr  (dec_dq),
        .dec_cmd_ddr (dec_cmd),
        .dec_async   (dec_async),
        .hit         (hit),
        .dq_ddr_en   (dq_ddr_en),
        .cmd_ddr_en  (cmd_ddr_en),
        .dq_async_en (dq_async_en),
        .sdio_mode   (sdio_mode),
        .slow_mode   (slow_mode)
    );

    phycfg_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .hit          (hit),
        .skip_write   (dec_skip),
        .clk_gate_ack (clk_gate_ack),
        .init_done    (init_done),
        .ready        (ready),
        .apply        (apply),
        .wr_en        (wr_en),
        .clk_gate_req (clk_gate_req),
        .init_start   (init_start),
        .req_done     (req_done)
    );

endmodule

// File: rtl/phy_mode_cfg_ctrl_checker.sv
module phy_mode_cfg_ctrl_checker #(
    parameter int MODE_W   = 4,
    parameter int DQ_LANES = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [MODE_W-1:0]   req_mode,
    input logic                req_fast,
    input logic                ready,
    input logic                clk_gate_req,
    input logic                clk_gate_ack,
    input logic                init_start,
    input logic [DQ_LANES-1:0] dq_ddr_en,
    input logic                cmd_ddr_en,
    input logic                dq_async_en,
    input logic                sdio_mode,
    input logic                slow_mode
);

    assert_slow_clear_fast_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid && req_fast) |=> !slow_mode);

    assert_func_only_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(clk_gate_req && clk_gate_ack) |=> $stable({dq_ddr_en, cmd_ddr_en, dq_async_en}));

    assert_init_ungated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |-> (!clk_gate_req && !clk_gate_ack));

    assert_idle_no_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !clk_gate_req);

    assert_init_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |=> !init_start);

    assert_legacy_keeps_sdio_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid && req_mode == '0) |=> $stable(sdio_mode));

endmodule

bind phy_mode_cfg_ctrl phy_mode_cfg_ctrl_checker #(.MODE_W(MODE_W), .DQ_LANES(DQ_LANES)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_mode     (req_mode),
    .req_fast     (req_fast),
    .ready        (ready),
    .clk_gate_req (clk_gate_req),
    .clk_gate_ack (clk_gate_ack),
    .init_start   (init_start),
    .dq_ddr_en    (dq_ddr_en),
    .cmd_ddr_en   (cmd_ddr_en),
    .dq_async_en  (dq_async_en),
    .sdio_mode    (sdio_mode),
    .slow_mode    (slow_mode)
);

// File: tb/phy_mode_cfg_ctrl_bench.sv
`timescale 1ns/1ps
module phy_mode_cfg_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [3:0] req_mode = '0;
    logic       req_fast = 1'b0;
    logic       req_sdio = 1'b0;
    logic       slow_strap = 1'b0;
    logic       clk_gate_ack = 1'b0;
    logic       init_done = 1'b0;
    logic       ready, req_done, clk_gate_req, init_start;
    logic [7:0] dq_ddr_en;
    logic       cmd_ddr_en, dq_async_en, sdio_mode, slow_mode;

    int n_checks = 0;
    int n_fail = 0;

    // expected model state
    logic [9:0] e_func = 10'b00_0000_0001;
    logic       e_sdio = 1'b0;
    logic       e_slow = 1'b0;
    logic       l_valid = 1'b0;
    logic [3:0] l_mode = '0;
    logic       l_fast = 1'b0;
    logic       l_sdio = 1'b0;

    always #2.5 clk = ~clk;

    phy_mode_cfg_ctrl u_phy_mode_cfg_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_fast(req_fast), .req_sdio(req_sdio), .slow_strap(slow_strap),
        .ready(ready), .req_done(req_done), .clk_gate_req(clk_gate_req),
        .clk_gate_ack(clk_gate_ack), .init_start(init_start), .init_done(init_done),
        .dq_ddr_en(dq_ddr_en), .cmd_ddr_en(cmd_ddr_en), .dq_async_en(dq_async_en),
        .sdio_mode(sdio_mode), .slow_mode(slow_mode)
    );

    function automatic logic f_slow(input logic [3:0] m, input logic f, input logic s, input logic st);
        if (f) return 1'b0;
        if (m == 4'd0) return st;
        if (m >= 4'd1 && m <= 4'd4) return s | st;
        return 1'b0;
    endfunction

    function automatic logic [9:0] f_func(input logic [3:0] m);
        if (m == 4'd10) return {8'hFF, 1'b1, 1'b0};
        if (m == 4'd7 || m == 4'd8) return {8'hFF, 1'b1, 1'b1};
        return {8'h00, 1'b0, 1'b1};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // environment: gate ack lags request by two cycles, init completes three cycles after start
    initial begin
        logic gd1;
        int   cnt;
        gd1 = 1'b0;
        cnt = 0;
        forever @(negedge clk) begin
            clk_gate_ack = gd1;
            gd1 = clk_gate_req;
            if (cnt != 0) begin
                cnt--;
                init_done = (cnt == 0);
            end else begin
                init_done = 1'b0;
            end
            if (init_start) cnt = 3;
        end
    end

    task automatic do_req(input logic [3:0] m, input logic f, input logic s, input logic st,
                          input logic intr, input logic [3:0] im);
        logic       hit, skip, slow, gated_prev, saw_gate, bad_write, done_seen;
        logic [9:0] fprev, fnow, exp_func;
        int         n_init, done_at;
        string      ftag;
        hit  = l_valid && m == l_mode && f == l_fast && s == l_sdio;
        slow = f_slow(m, f, s, st);
        skip = (m == 4'd0) || slow;
        if (!hit) begin
            e_slow = slow;
            if (m != 4'd0) e_sdio = s;
            if (!skip) e_func = f_func(m);
            l_valid = 1'b1; l_mode = m; l_fast = f; l_sdio = s;
        end
        exp_func = e_func;
        ftag = (hit || skip) ? "R9" : (m == 4'd10) ? "R2" : (m == 4'd7 || m == 4'd8) ? "R3" : "R4";
        req_mode = m; req_fast = f; req_sdio = s; slow_strap = st; req_valid = 1'b1;
        fprev = {dq_ddr_en, cmd_ddr_en, dq_async_en};
        gated_prev = 1'b0; saw_gate = 1'b0; bad_write = 1'b0; done_seen = 1'b0;
        n_init = 0; done_at = 0;
        for (int c = 1; c <= 40 && !done_seen; c++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (intr && c == 2) begin
                req_mode = im; req_fast = ~f; req_sdio = ~s; req_valid = 1'b1;
            end
            fnow = {dq_ddr_en, cmd_ddr_en, dq_async_en};
            if (fnow != fprev && !gated_prev) bad_write = 1'b1;
            fprev = fnow;
            gated_prev = clk_gate_req && clk_gate_ack;
            if (clk_gate_req) saw_gate = 1'b1;
            if (init_start) n_init++;
            if (req_done) begin
                done_seen = 1'b1;
                done_at = c;
            end
        end
        req_valid = 1'b0;
        check(done_seen, "R10 done", done_seen, 1);
        check(ready, "R10 ready", ready, 1);
        check(!bad_write, "R8 ungated write", bad_write, 0);
        check({dq_ddr_en, cmd_ddr_en, dq_async_en} == exp_func, ftag,
              {dq_ddr_en, cmd_ddr_en, dq_async_en}, exp_func);
        check(slow_mode == e_slow, f ? "R5" : "R6", slow_mode, e_slow);
        check(sdio_mode == e_sdio, "R7", sdio_mode, e_sdio);
        if (hit) begin
            check(done_at == 1, "R11 latency", done_at, 1);
            check(n_init == 0 && !saw_gate, "R11 no sequence", {saw_gate, 8'(n_init)}, 0);
        end else begin
            check(n_init == 1, "R10 init count", n_init, 1);
            if (skip) check(!saw_gate, "R9 gate", saw_gate, 0);
            else      check(saw_gate, "R8 gate", saw_gate, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check({dq_ddr_en, cmd_ddr_en, dq_async_en, sdio_mode, slow_mode} == 12'b0000_0000_0100,
              "R1 regs", {dq_ddr_en, cmd_ddr_en, dq_async_en, sdio_mode, slow_mode}, 12'h004);
        check(ready && !req_done && !clk_gate_req && !init_start, "R1 handshakes",
              {ready, req_done, clk_gate_req, init_start}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);

        do_req(4'd10, 1, 0, 0, 0, 0);   // R2 HS400
        do_req(4'd10, 1, 0, 0, 0, 0);   // R11 repeat
        do_req(4'd8,  1, 0, 0, 0, 0);   // R3 DDR52
        do_req(4'd7,  0, 1, 0, 0, 0);   // R3 DDR50, sdio
        do_req(4'd6,  1, 0, 1, 0, 0);   // R4 SDR104, R5 fast with strap
        do_req(4'd0,  0, 1, 1, 0, 0);   // R6 R7 R9 legacy with strap
        do_req(4'd1,  0, 1, 0, 0, 0);   // R6 MMC HS slow via sdio
        do_req(4'd2,  0, 0, 0, 0, 0);   // R4 SD HS not slow
        do_req(4'd9,  0, 1, 1, 0, 0);   // R6 HS200 low clock: not slow
        do_req(4'd13, 1, 1, 0, 0, 0);   // R4 undefined code
        do_req(4'd10, 1, 0, 0, 1, 4'd0);// R12 intruder while busy
        do_req(4'd10, 1, 0, 0, 0, 0);   // R12 intruder left no trace: hit
        do_req(4'd0,  1, 0, 1, 0, 0);   // R5 legacy fast with strap

        for (int i = 0; i < 300; i++) begin
            logic [3:0] m;
            m = 4'($urandom_range(0, 15));
            do_req(m, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom_range(0, 7) == 0),
                   4'($urandom_range(0, 15)));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule